// File: doc/BRIEF.md
# Serial Data Input Port

This block receives a compressed audio bitstream over a three-wire serial link: a data clock, a data line and a byte-sync strobe. It assembles the stream into bytes and queues them in a 64-entry FIFO for the decoder behind it. All three serial wires are brought into the system clock domain through a synchronizer. Edges of the data clock are then detected in that domain. Runtime configuration bits select the sampling edge and the bit order. A strobe on the byte-sync wire forces the bit counter back to the start of a byte, so a glitch on the link cannot leave the framing shifted.

The port works in one of two clocking roles. As a slave, the host drives the data clock. As a master, the port drives its own data clock at one of two rates, both derived from the system clock. The master clock rests low while the FIFO is full. A data-request output tells the host that the FIFO can take a further 32-byte burst. The bytes leave the FIFO on a valid/ready stream. `out_valid` stays high, and `out_data` does not change, until the consumer raises `out_ready`. A byte transfers on any rising system-clock edge where both are high. The consumer pushes back by holding `out_ready` low. The FIFO then fills. Once it is full, further bytes arriving on the serial side are discarded, and each discarded byte is reported on `drop_pulse`.

Top module: `sdin_port`

## Requirements
- R1: After reset, `out_valid` is 0, `data_req` is 1, `ser_clk_out` is 0 and `drop_pulse` is 0.
- R2: With `cfg_fall_edge` = 0, data is sampled on rising edges of the data clock. With `cfg_fall_edge` = 1, it is sampled on falling edges. Edges of the other polarity have no effect.
- R3: With `cfg_lsb_first` = 0, the first bit sampled in a byte becomes bit 7 of the byte. With `cfg_lsb_first` = 1, it becomes bit 0.
- R4: A sample taken while `ser_sync` is high becomes the first bit of a new byte, and any partly received byte is discarded.
- R5: With `cfg_master` = 0, the data clock is `ser_clk_in` and `ser_clk_out` is held at 0.
- R6: With `cfg_master` = 1, `ser_clk_in` is ignored and `ser_clk_out` becomes the data clock. Its period is 2*floor(CLK_KHZ/(2*SLOW_KHZ)) system cycles when `cfg_fast_clk` = 0, and 2*floor(CLK_KHZ/(2*FAST_KHZ)) when `cfg_fast_clk` = 1.
- R7: `data_req` is 1 exactly when the FIFO has at least BURST (32) free entries.
- R8: Bytes leave in arrival order through a FIFO of FIFO_DEPTH (64) entries. While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays the same.
- R9: A byte completed while the FIFO is full is dropped, `drop_pulse` is high for one cycle, and the FIFO contents do not change.
- R10: In master mode, `ser_clk_out` stays low while the FIFO is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_master | input | 1 | 1: the port drives the data clock; 0: the host drives it |
| cfg_fast_clk | input | 1 | Master clock rate: 0 slow, 1 fast |
| cfg_fall_edge | input | 1 | Sampling edge: 0 rising, 1 falling |
| cfg_lsb_first | input | 1 | Bit order: 0 MSB first, 1 LSB first |
| ser_clk_in | input | 1 | Data clock from the host (slave mode) |
| ser_dat | input | 1 | Serial data |
| ser_sync | input | 1 | Byte-sync strobe |
| ser_clk_out | output | 1 | Generated data clock (master mode) |
| data_req | output | 1 | FIFO has room for a 32-byte burst |
| out_valid | output | 1 | FIFO head byte is valid |
| out_ready | input | 1 | Consumer accepts the head byte |
| out_data | output | 8 | FIFO head byte |
| drop_pulse | output | 1 | One-cycle pulse for each byte dropped while full |

## Verification
The bench sends many byte values in all four combinations of edge and bit order. A port that used the wrong edge or reversed the bits would return mangled bytes. It moves the FIFO fill level across the 32-free boundary one byte at a time. An off-by-one `data_req` would fail at exactly 32 or 33 stored bytes. It sends three stray bits ahead of a synced byte, which catches a port that only resets its counter when the counter wraps. It overfills the FIFO, which catches a design that overwrites the oldest entry or fails to flag the drop. In master mode it measures the clock period at both rates and checks that the clock stops once the FIFO is full. A free-running clock would keep pulsing and lose data.

// File: rtl/sdin_pkg.sv
package sdin_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_CW = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sdin_sync_edge.sv
module sdin_sync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_clk,
  input  logic raw_dat,
  input  logic raw_sync,
  input  logic fall_sel,
  output logic samp_ev,
  output logic samp_dat,
  output logic samp_sync
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [2:0] chain [SYNC_STAGES];
  logic       clk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) chain[i] <= '0;
      clk_prev <= 1'b0;
    end else begin
      chain[0] <= {raw_sync, raw_dat, raw_clk};
      for (int i = 1; i < SYNC_STAGES; i++) chain[i] <= chain[i-1];
      clk_prev <= chain[LAST][0];
    end
  end

  logic rise_seen, fall_seen;
  always_comb begin
    rise_seen = chain[LAST][0] & ~clk_prev;
    fall_seen = ~chain[LAST][0] & clk_prev;
    samp_ev   = fall_sel ? fall_seen : rise_seen;
    samp_dat  = chain[LAST][1];
    samp_sync = chain[LAST][2];
  end
endmodule

// File: rtl/sdin_deser.sv
module sdin_deser
  import sdin_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  samp_ev,
  input  logic  samp_dat,
  input  logic  samp_sync,
  input  logic  lsb_first,
  output logic  byte_vld,
  output byte_t byte_dat
);
  logic [BIT_CW-1:0] bit_cnt;
  logic [BIT_CW-1:0] bit_idx;
  byte_t             shreg;
  byte_t             shreg_nxt;

  always_comb begin
    bit_idx   = samp_sync ? '0 : bit_cnt;
    shreg_nxt = lsb_first ? {samp_dat, shreg[BYTE_W-1:1]}
                          : {shreg[BYTE_W-2:0], samp_dat};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_dat <= '0;
    end else begin
      byte_vld <= 1'b0;
      if (samp_ev) begin
        shreg <= shreg_nxt;
        if (bit_idx == BIT_CW'(BYTE_W - 1)) begin
          bit_cnt  <= '0;
          byte_vld <= 1'b1;
          byte_dat <= shreg_nxt;
        end else begin
          bit_cnt <= bit_idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sdin_fifo.sv
module sdin_fifo #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             not_empty,
  output logic             full,
  output logic [CW-1:0]    count,
  output logic             drop
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic             push_ok, pop_ok;

  always_comb begin
    full      = (count == CW'(DEPTH));
    not_empty = (count != '0);
    push_ok   = push & ~full;
    pop_ok    = pop & not_empty;
    head      = mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      drop  <= 1'b0;
    end else begin
      drop <= push & full;
      if (push_ok) wptr <= wptr + 1'b1;
      if (pop_ok)  rptr <= rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sdin_mclk_gen.sv
module sdin_mclk_gen #(
  parameter int HALF_SLOW = 24,
  parameter int HALF_FAST = 12,
  localparam int HW = $clog2(HALF_SLOW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic fast,
  input  logic hold,
  output logic mclk
);
  logic [HW-1:0] div_cnt;
  logic [HW-1:0] div_lim;

  assign div_lim = fast ? HW'(HALF_FAST - 1) : HW'(HALF_SLOW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      mclk    <= 1'b0;
    end else if (!enable) begin
      div_cnt <= '0;
      mclk    <= 1'b0;
    end else if (!mclk && hold) begin
      div_cnt <= '0;
    end else if (div_cnt >= div_lim) begin
      div_cnt <= '0;
      mclk    <= ~mclk;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sdin_port.sv
module sdin_port
  import sdin_pkg::*;
#(
  parameter int CLK_KHZ     = 24576,
  parameter int SLOW_KHZ    = 512,
  parameter int FAST_KHZ    = 1024,
  parameter int FIFO_DEPTH  = 64,
  parameter int BURST       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_master,
  input  logic              cfg_fast_clk,
  input  logic              cfg_fall_edge,
  input  logic              cfg_lsb_first,
  input  logic              ser_clk_in,
  input  logic              ser_dat,
  input  logic              ser_sync,
  output logic              ser_clk_out,
  output logic              data_req,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              drop_pulse
);
  localparam int HALF_SLOW = CLK_KHZ / (2 * SLOW_KHZ);
  localparam int HALF_FAST = CLK_KHZ / (2 * FAST_KHZ);
  localparam int CW        = $clog2(FIFO_DEPTH) + 1;

  logic    mclk, dclk_sel;
  logic    samp_ev, samp_dat, samp_sync;
  logic    byte_vld;
  byte_t   byte_dat;
  logic    fifo_full;
  logic [CW-1:0] fifo_cnt;
  logic [CW-1:0] fifo_free;

  sdin_mclk_gen #(
    .HALF_SLOW(HALF_SLOW),
    .HALF_FAST(HALF_FAST)
  ) mclk_i (
    .clk(clk), .rst_n(rst_n), .enable(cfg_master), .fast(cfg_fast_clk),
    .hold(fifo_full), .mclk(mclk)
  );

  assign dclk_sel    = cfg_master ? mclk : ser_clk_in;
  assign ser_clk_out = mclk;

  sdin_sync_edge #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw_clk(dclk_sel), .raw_dat(ser_dat),
    .raw_sync(ser_sync), .fall_sel(cfg_fall_edge), .samp_ev(samp_ev),
    .samp_dat(samp_dat), .samp_sync(samp_sync)
  );

  sdin_deser deser_i (
    .clk(clk), .rst_n(rst_n), .samp_ev(samp_ev), .samp_dat(samp_dat),
    .samp_sync(samp_sync), .lsb_first(cfg_lsb_first),
    .byte_vld(byte_vld), .byte_dat(byte_dat)
  );

  sdin_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(byte_vld), .push_data(byte_dat),
    .pop(out_ready), .head(out_data), .not_empty(out_valid),
    .full(fifo_full), .count(fifo_cnt), .drop(drop_pulse)
  );

  assign fifo_free = CW'(FIFO_DEPTH) - fifo_cnt;
  assign data_req  = (fifo_free >= CW'(BURST));
endmodule

// File: rtl/sdin_port_chk.sv
module sdin_port_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_master,
  input logic          ser_clk_out,
  input logic          data_req,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_data,
  input logic          drop_pulse,
  input logic [CW-1:0] fifo_cnt
);
  always @(posedge clk) begin
    if (rst_n) begin
      a_r8_no_overflow: assert (fifo_cnt <= CW'(DEPTH))
        else $error("fifo count above depth");
    end
  end

  a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r9_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> $past(fifo_cnt) == CW'(DEPTH));

  a_r7_req_rise_on_pop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_req) |-> $past(out_valid && out_ready));

  a_r5_slave_clk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |=> !ser_clk_out);

  a_r10_idle_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && fifo_cnt == CW'(DEPTH) && !ser_clk_out |=> !ser_clk_out);
endmodule

bind sdin_port sdin_port_chk #(.DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .ser_clk_out(ser_clk_out),
  .data_req(data_req), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .drop_pulse(drop_pulse), .fifo_cnt(fifo_cnt)
);

// File: tb/sdin_port_tb_top.sv
`timescale 1ns/1ps
module sdin_port_tb_top;
  localparam int DEPTH = 64;
  localparam int BURST = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_master = 1'b0, cfg_fast_clk = 1'b0, cfg_fall_edge = 1'b0, cfg_lsb_first = 1'b0;
  logic ser_clk_in = 1'b0, ser_dat = 1'b0, ser_sync = 1'b0, out_ready = 1'b0;
  logic ser_clk_out, data_req, out_valid, drop_pulse;
  logic [7:0] out_data;

  sdin_port #(.CLK_KHZ(8192)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_fast_clk(cfg_fast_clk),
    .cfg_fall_edge(cfg_fall_edge), .cfg_lsb_first(cfg_lsb_first),
    .ser_clk_in(ser_clk_in), .ser_dat(ser_dat), .ser_sync(ser_sync),
    .ser_clk_out(ser_clk_out), .data_req(data_req), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .drop_pulse(drop_pulse)
  );

  int checks = 0, errors = 0, ovf_seen = 0;
  bit done = 1'b0;

  always @(negedge clk) if (rst_n && drop_pulse) ovf_seen++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bit(input logic b, input logic s);
    if (!cfg_fall_edge) begin
      ser_clk_in = 1'b0; ser_dat = b; ser_sync = s; tick(4);
      ser_clk_in = 1'b1; tick(4);
    end else begin
      ser_clk_in = 1'b1; ser_dat = b; ser_sync = s; tick(4);
      ser_clk_in = 1'b0; tick(4);
    end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++)
      send_bit(cfg_lsb_first ? v[i] : v[7-i], i == 0);
    ser_sync = 1'b0;
    tick(8);
  endtask

  task automatic pop_expect(input logic [7:0] exp, input string req);
    chk(out_valid === 1'b1, req, int'(out_valid), 1);
    chk(out_data === exp, req, int'(out_data), int'(exp));
    out_ready = 1'b1; tick(1); out_ready = 1'b0;
  endtask

  task automatic drain_count(output int n);
    n = 0;
    for (int k = 0; k < 2 * DEPTH && out_valid; k++) begin
      out_ready = 1'b1; tick(1); out_ready = 1'b0; n++;
    end
  endtask

  task automatic wait_fall();
    logic prev;
    prev = ser_clk_out;
    for (int k = 0; k < 400; k++) begin
      tick(1);
      if (prev && !ser_clk_out) break;
      prev = ser_clk_out;
    end
  endtask

  task automatic master_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      wait_fall();
      ser_dat = v[7-i]; ser_sync = (i == 0);
      ser_clk_in = ~ser_clk_in;
    end
    wait_fall();
    ser_sync = 1'b0;
  endtask

  task automatic measure_period(output int per);
    int c, first;
    logic prev;
    c = 0; first = -1; per = 0; prev = ser_clk_out;
    for (int k = 0; k < 400; k++) begin
      tick(1); c++;
      if (!prev && ser_clk_out) begin
        if (first < 0) first = c;
        else begin per = c - first; break; end
      end
      prev = ser_clk_out;
    end
  endtask

  function automatic logic [7:0] pat(input int cfg, input int blk, input int i);
    if (cfg == 0) return 8'(blk * 64 + i);
    return 8'(i * 37 + cfg * 59);
  endfunction

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, per, ovf0;
    tick(5);
    // R1 reset state
    chk(out_valid === 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(data_req === 1'b1, "R1 data_req", int'(data_req), 1);
    chk(ser_clk_out === 1'b0, "R1 ser_clk_out", int'(ser_clk_out), 0);
    chk(drop_pulse === 1'b0, "R1 drop_pulse", int'(drop_pulse), 0);
    rst_n = 1'b1; tick(4);

    // R2 R3 R7 R8: edge/order sweep, fill level boundary per byte
    for (int cfg = 0; cfg < 4; cfg++) begin
      cfg_fall_edge = cfg[0]; cfg_lsb_first = cfg[1];
      for (int blk = 0; blk < ((cfg == 0) ? 4 : 1); blk++) begin
        for (int i = 0; i < DEPTH; i++) begin
          send_byte(pat(cfg, blk, i));
          chk(data_req === ((DEPTH - 1 - i) >= BURST), "R7 data_req vs free",
              int'(data_req), int'((DEPTH - 1 - i) >= BURST));
        end
        for (int i = 0; i < DEPTH; i++) pop_expect(pat(cfg, blk, i), "R2 R3 R8 byte");
        chk(out_valid === 1'b0, "R8 empty after drain", int'(out_valid), 0);
      end
    end

    // R4 sync realignment after stray bits
    cfg_fall_edge = 1'b0; cfg_lsb_first = 1'b0;
    send_bit(1'b1, 1'b0); send_bit(1'b0, 1'b0); send_bit(1'b1, 1'b0);
    send_byte(8'h5A);
    pop_expect(8'h5A, "R4 synced byte");
    chk(out_valid === 1'b0, "R4 no extra byte", int'(out_valid), 0);

    // R9 drop while full
    for (int i = 0; i < DEPTH; i++) send_byte(8'(i + 3));
    ovf0 = ovf_seen;
    send_byte(8'hEE);
    chk(ovf_seen == ovf0 + 1, "R9 drop pulse", ovf_seen - ovf0, 1);
    for (int i = 0; i < DEPTH; i++) pop_expect(8'(i + 3), "R9 contents kept");
    chk(out_valid === 1'b0, "R9 dropped byte absent", int'(out_valid), 0);

    // R5 slave: generated clock stays low while host clock toggles
    n = 0;
    for (int k = 0; k < 40; k++) begin
      ser_clk_in = ~ser_clk_in; tick(1);
      if (ser_clk_out !== 1'b0) n++;
    end
    chk(n == 0, "R5 ser_clk_out idle in slave", n, 0);
    ser_clk_in = 1'b0; tick(8); drain_count(n);

    // R6 master periods
    cfg_master = 1'b1; cfg_fast_clk = 1'b0;
    measure_period(per);
    chk(per == 16, "R6 slow period", per, 16);
    cfg_fast_clk = 1'b1;
    measure_period(per); measure_period(per);
    chk(per == 8, "R6 fast period", per, 8);
    cfg_master = 1'b0; tick(10); drain_count(n);

    // R6 master receive, host clock ignored
    cfg_master = 1'b1; cfg_fast_clk = 1'b0;
    master_byte(8'hC3); master_byte(8'h3C);
    cfg_master = 1'b0; ser_clk_in = 1'b0; tick(10);
    pop_expect(8'hC3, "R6 master byte 0");
    pop_expect(8'h3C, "R6 master byte 1");
    chk(out_valid === 1'b0, "R6 no stray byte", int'(out_valid), 0);

    // R10 master clock idles when full
    ser_dat = 1'b1; ser_sync = 1'b0;
    cfg_master = 1'b1; cfg_fast_clk = 1'b1;
    tick(DEPTH * 8 * 8 + 300);
    chk(data_req === 1'b0, "R10 fifo filled", int'(data_req), 0);
    n = 0;
    for (int k = 0; k < 60; k++) begin
      tick(1);
      if (ser_clk_out !== 1'b0) n++;
    end
    chk(n == 0, "R10 clock idle while full", n, 0);
    cfg_master = 1'b0; tick(10);
    drain_count(n);
    chk(n == DEPTH, "R10 stored count", n, DEPTH);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule